// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to the fetch program counter and repeats a range of instructions a set number of times without any branch instruction in the body. A setup command gives a pass count, the address of the first body instruction and the address of the last body instruction. Each time the fetch address matches the last-body address of the innermost loop, the controller decides in the same cycle whether to send the next fetch back to the first body instruction or to let it fall through. The count is reduced by one on each return, and the loop retires after its final pass.

Loops nest through a small hardware stack of loop contexts. Only the innermost context is compared with the fetch address. When it retires, the context below becomes the one that is checked. A setup with a pass count of zero skips the body. A setup that arrives while every stack slot is in use sets a sticky error flag and leaves the stored contexts untouched.

The override is a combinational function of the current fetch address and the setup command, so there is no bubble at a loop boundary. In a cycle that carries a setup command, no loop-end check is made.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, `depth` is 0, `loop_active` is 0, `overflow_err` is 0, and `redirect_valid` is 0 for any fetch address.
- R2: A setup with a nonzero count, made while the stack is not full, adds one context. `depth` rises by one and `loop_active` is 1 from the next cycle.
- R3: When a valid fetch address equals the innermost loop's last-body address and that loop has more than one pass left, `redirect_valid` is 1 in the same cycle and `redirect_pc` is that loop's first-body address.
- R4: A loop set up with count N (N >= 1) runs its body exactly N times. After the last pass, fetch falls through (`redirect_valid` is 0) and `depth` falls by one in the next cycle.
- R5: After an inner loop retires, the next loop out resumes its own end-address check, so an outer loop of count M around an inner loop of count K runs the inner body M*K times.
- R6: If the inner and outer loops end on the same address, only the innermost context is evaluated. When the inner loop retires there, fetch falls through even though the outer loop has passes left, and the outer context stays on the stack.
- R7: A setup with count 0 sets `redirect_valid` in that same cycle with `redirect_pc` equal to the last-body address plus one, and adds no context.
- R8: With DEPTH contexts held, a setup with a nonzero count sets `overflow_err`, which stays at 1 until reset. `depth` does not change, and the stored contexts keep their addresses and remaining counts.
- R9: A fetch with `fetch_valid` at 0, or at an address other than the innermost last-body address, produces no redirect and leaves the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Loop setup command present this cycle |
| setup_count | input | CW | Number of passes through the body |
| setup_start | input | AW | Address of the first body instruction |
| setup_end | input | AW | Address of the last body instruction |
| fetch_valid | input | 1 | `fetch_pc` holds a real fetch this cycle |
| fetch_pc | input | AW | Current fetch address |
| redirect_valid | output | 1 | Next fetch must use `redirect_pc` |
| redirect_pc | output | AW | Override for the next fetch address |
| loop_active | output | 1 | At least one loop context is held |
| depth | output | $clog2(DEPTH+1) | Number of contexts held |
| overflow_err | output | 1 | Sticky flag: a setup found the stack full |

## Verification
The assertions assume that the sequencer never gives a setup command in a cycle whose fetch address is a loop end. They also assume that a pass count is never larger than the count field can hold and that the first-body address precedes the last-body address. The bench runs its programs as a small fetch model that advances by one address per cycle or follows the override. Its setup commands sit only at addresses that are not loop ends, so every sweep stays within these assumptions. Where the stack overflow and idle fetches are tested, setup commands are driven with `fetch_valid` low and are never mixed with a loop-end fetch.

// File: rtl/zol_pkg.sv
package zol_pkg;

  // Action chosen for the loop stack in one cycle
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_PUSH    = 2'd1,
    ACT_ADVANCE = 2'd2,
    ACT_RETIRE  = 2'd3
  } zol_act_e;

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_start,
  input  logic [AW-1:0] push_end,
  input  logic [CW-1:0] push_count,
  input  logic          pop,
  input  logic          dec,
  output logic [AW-1:0] top_start,
  output logic [AW-1:0] top_end,
  output logic [CW-1:0] top_count,
  output logic [DW-1:0] level,
  output logic          full
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] slot_start [DEPTH];
  logic [AW-1:0] slot_end   [DEPTH];
  logic [CW-1:0] slot_count [DEPTH];
  logic [DW-1:0] level_q;
  logic [IW-1:0] top_idx;

  // Per-slot write: a push fills the slot just above the top,
  // a decrement rewrites the count of the top slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && level_q == DW'(g)) begin
        slot_start[g] <= push_start;
        slot_end[g]   <= push_end;
        slot_count[g] <= push_count;
      end else if (dec && level_q == DW'(g + 1)) begin
        slot_count[g] <= slot_count[g] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else if (push) begin
      level_q <= level_q + DW'(1);
    end else if (pop) begin
      level_q <= level_q - DW'(1);
    end
  end

  always_comb begin
    if (level_q == '0) begin
      top_idx = '0;
    end else begin
      top_idx = IW'(level_q - DW'(1));
    end
  end

  assign top_start = slot_start[top_idx];
  assign top_end   = slot_end[top_idx];
  assign top_count = slot_count[top_idx];
  assign level     = level_q;
  assign full      = (level_q == DW'(DEPTH));

  AST_STACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    push |-> !(pop || dec)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop || dec) |-> level_q != '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> level_q != DW'(DEPTH)); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level_q <= DW'(DEPTH)); // R8

endmodule

// File: rtl/zol_decide.sv
module zol_decide
  import zol_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          setup_valid,
  input  logic [CW-1:0] setup_count,
  input  logic [AW-1:0] setup_end,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          held,
  input  logic          full,
  input  logic [AW-1:0] top_start,
  input  logic [AW-1:0] top_end,
  input  logic [CW-1:0] top_count,
  output zol_act_e      act,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          ovf_set
);

  logic end_hit;

  // Only the innermost context is compared with the fetch address.
  assign end_hit = fetch_valid && held && (fetch_pc == top_end);

  always_comb begin
    act            = ACT_NONE;
    redirect_valid = 1'b0;
    redirect_pc    = top_start;
    ovf_set        = 1'b0;
    if (setup_valid) begin
      if (setup_count == '0) begin
        redirect_valid = 1'b1;
        redirect_pc    = setup_end + AW'(1);
      end else if (full) begin
        ovf_set = 1'b1;
      end else begin
        act = ACT_PUSH;
      end
    end else if (end_hit) begin
      if (top_count > CW'(1)) begin
        act            = ACT_ADVANCE;
        redirect_valid = 1'b1;
      end else begin
        act = ACT_RETIRE;
      end
    end
  end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int CW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       setup_valid,
  input  logic [CW-1:0]              setup_count,
  input  logic [AW-1:0]              setup_start,
  input  logic [AW-1:0]              setup_end,
  input  logic                       fetch_valid,
  input  logic [AW-1:0]              fetch_pc,
  output logic                       redirect_valid,
  output logic [AW-1:0]              redirect_pc,
  output logic                       loop_active,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       overflow_err
);

  localparam int DW = $clog2(DEPTH + 1);

  zol_act_e      act;
  logic          ovf_set;
  logic          stk_full;
  logic [DW-1:0] level;
  logic [AW-1:0] top_start;
  logic [AW-1:0] top_end;
  logic [CW-1:0] top_count;
  logic          err_q;

  zol_stack #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .CW    (CW),
    .DW    (DW)
  ) u_stack (
    .clk        (clk),
    .rst        (rst),
    .push       (act == ACT_PUSH),
    .push_start (setup_start),
    .push_end   (setup_end),
    .push_count (setup_count),
    .pop        (act == ACT_RETIRE),
    .dec        (act == ACT_ADVANCE),
    .top_start  (top_start),
    .top_end    (top_end),
    .top_count  (top_count),
    .level      (level),
    .full       (stk_full)
  );

  zol_decide #(
    .AW (AW),
    .CW (CW)
  ) u_decide (
    .setup_valid    (setup_valid),
    .setup_count    (setup_count),
    .setup_end      (setup_end),
    .fetch_valid    (fetch_valid),
    .fetch_pc       (fetch_pc),
    .held           (level != '0),
    .full           (stk_full),
    .top_start      (top_start),
    .top_end        (top_end),
    .top_count      (top_count),
    .act            (act),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .ovf_set        (ovf_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (ovf_set) begin
      err_q <= 1'b1;
    end
  end

  assign overflow_err = err_q;
  assign loop_active  = (level != '0);
  assign depth        = level;

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_count != '0 && depth != DW'(DEPTH))
      |=> depth == $past(depth) + DW'(1)); // R2
  AST_ADVANCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!setup_valid && redirect_valid) |=> depth == $past(depth)); // R3
  AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (!setup_valid && fetch_valid && loop_active && !redirect_valid && fetch_pc == top_end)
      |=> depth == $past(depth) - DW'(1)); // R4
  AST_ZERO_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_count == '0) |=> depth == $past(depth)); // R7
  AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (setup_valid && setup_count != '0 && depth == DW'(DEPTH))
      |=> (overflow_err && depth == $past(depth))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow_err |=> overflow_err); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!setup_valid && !loop_active) |-> !redirect_valid); // R9
  AST_NO_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!setup_valid && !fetch_valid) |=> depth == $past(depth)); // R9

endmodule

// File: tb/zol_ctrl_bench.sv
module zol_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          setup_valid = 1'b0;
  logic [CW-1:0] setup_count = '0;
  logic [AW-1:0] setup_start = '0;
  logic [AW-1:0] setup_end = '0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic          loop_active;
  logic [2:0]    depth;
  logic          overflow_err;

  int checks = 0;
  int errors = 0;
  int visits [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  zol_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_zol_ctrl (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_count(setup_count),
    .setup_start(setup_start), .setup_end(setup_end), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .loop_active(loop_active), .depth(depth), .overflow_err(overflow_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; setup_valid = 1'b0; fetch_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One cycle of stimulus driven at the falling edge; outputs read 1 time unit later
  task automatic step(input bit sv, input int cnt, input int st, input int en,
                      input bit fv, input int pc);
    @(negedge clk);
    setup_valid = sv; setup_count = CW'(cnt); setup_start = AW'(st); setup_end = AW'(en);
    fetch_valid = fv; fetch_pc = AW'(pc);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  // Fetch model: mode 0 single loop, mode 1 nested, mode 2 shared end address
  task automatic run_prog(input int mode, input int n1, input int n2, input int l,
                          input int pc0, input int stop_pc, output int cyc);
    int pc;
    for (int i = 0; i < 64; i++) visits[i] = 0;
    pc = pc0;
    cyc = 0;
    while (pc != stop_pc && cyc < 4000) begin
      if (mode == 0 && pc == 4)      step(1, n1, 5, 4 + l, 1, pc);
      else if (mode == 1 && pc == 8) step(1, n1, 9, 14, 1, pc);
      else if (mode == 1 && pc == 9) step(1, n2, 10, 12, 1, pc);
      else if (mode == 2 && pc == 8) step(1, n1, 9, 12, 1, pc);
      else if (mode == 2 && pc == 9) step(1, n2, 10, 12, 1, pc);
      else                           step(0, 0, 0, 0, 1, pc);
      visits[pc]++;
      cyc++;
      pc = redirect_valid ? int'(redirect_pc) : pc + 1;
    end
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    do_reset();

    // R1: reset state
    step(0, 0, 0, 0, 1, 0);
    check(depth == 0, "R1 depth", int'(depth), 0);
    check(!loop_active, "R1 loop_active", int'(loop_active), 0);
    check(!overflow_err, "R1 overflow_err", int'(overflow_err), 0);
    check(!redirect_valid, "R1 redirect", int'(redirect_valid), 0);

    // R4 R7: single loop sweep, count 0..15, body length 1..4
    for (int n = 0; n < 16; n++) begin
      for (int l = 1; l <= 4; l++) begin
        do_reset();
        run_prog(0, n, 0, l, 0, 5 + l, cyc);
        check(visits[5] == n, "R4 body passes", visits[5], n);
        check(cyc == 5 + n * l, "R4 cycle count", cyc, 5 + n * l);
        check(depth == 0, "R4 depth after", int'(depth), 0);
      end
    end

    // R7: zero count redirect in the setup cycle
    do_reset();
    step(1, 0, 20, 27, 1, 19);
    check(redirect_valid && redirect_pc == 28, "R7 skip target", int'(redirect_pc), 28);
    idle();
    check(depth == 0, "R7 no push", int'(depth), 0);

    // R2 R5: nested sweep
    for (int m = 1; m <= 4; m++) begin
      for (int k = 0; k <= 3; k++) begin
        do_reset();
        run_prog(1, m, k, 0, 8, 15, cyc);
        check(visits[10] == m * k, "R5 inner passes", visits[10], m * k);
        check(visits[13] == m, "R5 outer passes", visits[13], m);
        check(depth == 0, "R2 depth after nest", int'(depth), 0);
      end
    end

    // R6: shared end address
    for (int m = 1; m <= 3; m++) begin
      for (int k = 1; k <= 3; k++) begin
        do_reset();
        run_prog(2, m, k, 0, 8, 13, cyc);
        check(visits[10] == k, "R6 inner passes", visits[10], k);
        check(visits[9] == 1, "R6 outer not repeated", visits[9], 1);
        check(depth == 1 && loop_active, "R6 outer held", int'(depth), 1);
      end
    end

    // R2 R8 R5: fill the stack, overflow, then unwind
    do_reset();
    for (int k = 0; k < 4; k++) begin
      step(1, 2, 16 * k + 1, 16 * k + 3, 0, 0);
      idle();
      check(depth == 3'(k + 1) && loop_active, "R2 push depth", int'(depth), k + 1);
    end
    step(1, 5, 100, 110, 0, 0);
    idle();
    check(overflow_err == 1, "R8 flag set", int'(overflow_err), 1);
    check(depth == 4, "R8 depth unchanged", int'(depth), 4);
    step(0, 0, 0, 0, 1, 51);
    check(redirect_valid && redirect_pc == 49, "R8 top intact", int'(redirect_pc), 49);
    step(0, 0, 0, 0, 1, 51);
    check(!redirect_valid, "R8 top count intact", int'(redirect_valid), 0);
    idle();
    check(depth == 3, "R4 retire depth", int'(depth), 3);
    step(0, 0, 0, 0, 1, 35);
    check(redirect_valid && redirect_pc == 33, "R5 outer resumes", int'(redirect_pc), 33);
    idle();
    check(overflow_err == 1, "R8 flag sticky", int'(overflow_err), 1);

    // R9: ignored fetches leave the count alone
    do_reset();
    step(1, 3, 1, 3, 0, 0);
    step(0, 0, 0, 0, 0, 3);
    check(!redirect_valid, "R9 invalid fetch", int'(redirect_valid), 0);
    step(0, 0, 0, 0, 1, 2);
    check(!redirect_valid, "R9 non-end address", int'(redirect_valid), 0);
    for (int p = 0; p < 3; p++) begin
      step(0, 0, 0, 0, 1, 3);
      check(redirect_valid == (p < 2), "R9 count preserved", int'(redirect_valid), int'(p < 2));
    end
    idle();
    check(depth == 0, "R9 retired", int'(depth), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule